// File: doc/BRIEF.md
# Fourth-Order Sinc Decimator with Output Clamping

This block turns the one-bit output of a delta-sigma modulator into signed 24-bit conversion words. Each accepted bit counts as +1 or -1. The bits pass through four cascaded running-sum stages at the modulator rate. The sums are then decimated by `DECIM`, which is 256 by default. Four cascaded difference stages follow. The result is a fourth-order sinc low-pass whose -3 dB corner sits near a quarter of the output word rate. The filtered value is scaled down to 24 bits and clamped to the two's complement range.

Two conversion modes are available. In single-shot mode, a start request clears the filter and runs exactly one conversion. The block then clears its state again and waits. In free-running mode, the filter state is carried from one word to the next, so a new word appears every `DECIM` accepted samples for as long as the mode input stays high.

Both data edges are valid-only streams with no ready signal and no back-pressure:
- The modulator presents one bit on every cycle that `mod_en` is high, and that bit is taken.
- Each `result_valid` pulse carries a word that the consumer must take in that same cycle.
- `result` holds its value until the next pulse.

Top module: `sinc4_decim`

## Requirements
- R1: A bit is taken only on a cycle with `mod_en` high while a conversion is active: 1 counts as +1 and 0 as -1. The word produced when sample n (counted from 1 at conversion start) is taken equals a weighted sum of samples n-4R+1 through n-3, where R = `DECIM`. The weights are the fourfold self-convolution of an all-ones window of length R, and samples before the start count as zero. This sum is shifted right arithmetically (floor) by 4*log2(R)-23 bits.
- R2: In single-shot mode (`cont_mode` low), a start request while idle begins a conversion from cleared state. The conversion yields exactly one word, when its 4R-th sample is taken. The state is then cleared and the block goes idle, ignoring samples until the next start.
- R3: In free-running mode, the first word comes with the 4R-th sample and further words follow every R samples, with no clearing in between. If `cont_mode` is low in the cycle a word completes, that word is the last one and the state is cleared.
- R4: A scaled value above 0x7FFFFF gives 0x7FFFFF, and one below -2^23 gives 0x800000. Constant ones therefore give 0x7FFFFF, constant zeros give 0x800000, and an alternating pattern gives 0x000000.
- R5: A start request during a conversion is ignored. The exception is the cycle in which the final word of a conversion completes: there the start begins a new, cleared conversion at once.
- R6: `result_valid` is high for one clock, in the cycle after the clock edge that takes the completing sample. `result` changes only with that pulse.
- R7: Cycles with `mod_en` low take no sample, so gaps in the enable leave the words unchanged.
- R8: During and after reset, `result_valid` is 0, `result` is 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| mod_en | input | 1 | Modulator-rate enable; a bit is taken when high |
| cont_mode | input | 1 | 1 = free-running, 0 = single-shot |
| start | input | 1 | Conversion start request |
| result | output | 24 | Clamped two's complement conversion word |
| result_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
Two events can land in the same cycle. One is the completion of a conversion's final word; the other is either a fresh start request or the fall of `cont_mode` in free-running mode. The bench raises `start` together with the last sample of a single-shot conversion. It then checks that the word is still delivered and that a second conversion follows from cleared state, delivering its word exactly 4R samples later. It also lowers `cont_mode` just before a free-running word completes and checks that this word is the last. Every word is compared against an independent convolution model of the sinc weights.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;

  // Conversion controller state.
  typedef enum logic {
    CONV_IDLE = 1'b0,
    CONV_RUN  = 1'b1
  } conv_state_e;

  // Accumulator width that holds the full filter gain plus sign and guard.
  function automatic int unsigned sinc_acc_width(int unsigned order, int unsigned log2r);
    return order * log2r + 2;
  endfunction

endpackage

// File: rtl/sinc4_integ.sv
// Cascade of running-sum stages at modulator rate; wraparound arithmetic.
module sinc4_integ #(
  parameter int unsigned ORDER = 4,
  parameter int unsigned ACC_W = 34
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] tap
);

  localparam logic signed [ACC_W-1:0] PLUS_ONE  = {{(ACC_W-1){1'b0}}, 1'b1};
  localparam logic signed [ACC_W-1:0] MINUS_ONE = {ACC_W{1'b1}};

  logic signed [ACC_W-1:0] acc  [ORDER];
  logic signed [ACC_W-1:0] feed [ORDER];

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic signed [ACC_W-1:0] sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q <= '0;
      end else if (clr) begin
        sum_q <= '0;
      end else if (en) begin
        sum_q <= sum_q + feed[g];
      end
    end

    assign acc[g] = sum_q;

    if (g == 0) begin : g_first
      assign feed[g] = bit_in ? PLUS_ONE : MINUS_ONE;
    end else begin : g_next
      assign feed[g] = acc[g-1];
    end
  end

  // Value the last stage takes after the current update, so the window
  // lines up with the first sample of a conversion.
  assign tap = acc[ORDER-1] + feed[ORDER-1];

endmodule

// File: rtl/sinc4_comb.sv
// Cascade of difference stages at the decimated rate.
module sinc4_comb #(
  parameter int unsigned ORDER = 4,
  parameter int unsigned ACC_W = 34
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);

  logic signed [ACC_W-1:0] stage_in  [ORDER];
  logic signed [ACC_W-1:0] stage_out [ORDER];

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic signed [ACC_W-1:0] dly_q;

    if (g == 0) begin : g_first
      assign stage_in[g] = din;
    end else begin : g_next
      assign stage_in[g] = stage_out[g-1];
    end

    assign stage_out[g] = stage_in[g] - dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dly_q <= '0;
      end else if (clr) begin
        dly_q <= '0;
      end else if (load) begin
        dly_q <= stage_in[g];
      end
    end
  end

  assign dout = stage_out[ORDER-1];

endmodule

// File: rtl/sinc4_scale.sv
// Scale the filter output to the word width (floor), then clamp.
module sinc4_scale #(
  parameter int unsigned ACC_W = 34,
  parameter int unsigned OUT_W = 24,
  parameter int unsigned FRAC  = 32
) (
  input  logic signed [ACC_W-1:0] din,
  output logic        [OUT_W-1:0] dout
);

  localparam int SHIFT = int'(FRAC) - int'(OUT_W) + 1;
  localparam logic signed [ACC_W-1:0] MAX_CODE =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MIN_CODE =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] scaled;

  if (SHIFT >= 0) begin : g_down
    assign scaled = din >>> SHIFT;
  end else begin : g_up
    assign scaled = din <<< (-SHIFT);
  end

  always_comb begin
    if (scaled > MAX_CODE) begin
      dout = MAX_CODE[OUT_W-1:0];
    end else if (scaled < MIN_CODE) begin
      dout = MIN_CODE[OUT_W-1:0];
    end else begin
      dout = scaled[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/sinc4_ctrl.sv
// Conversion sequencing: sample count, priming count, mode handling.
module sinc4_ctrl
  import sinc4_pkg::*;
#(
  parameter int unsigned DECIM = 256,
  parameter int unsigned ORDER = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_en,
  input  logic cont_mode,
  input  logic start,
  output logic busy,
  output logic step,
  output logic boundary,
  output logic emit,
  output logic state_clr
);

  localparam int unsigned CNT_W = $clog2(DECIM);
  localparam int unsigned PER_W = $clog2(ORDER + 1);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(DECIM - 1);
  localparam logic [PER_W-1:0] PER_FULL  = PER_W'(ORDER);
  localparam logic [PER_W-1:0] PER_PRIME = PER_W'(ORDER - 1);

  conv_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PER_W-1:0] per_q;
  logic             finish;
  logic             accept;

  assign busy      = (state_q == CONV_RUN);
  assign step      = busy && mod_en;
  assign boundary  = step && (cnt_q == CNT_LAST);
  assign emit      = boundary && (per_q >= PER_PRIME);
  assign finish    = emit && !cont_mode;
  assign accept    = start && (!busy || finish);
  assign state_clr = accept || finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CONV_IDLE;
      cnt_q   <= '0;
      per_q   <= '0;
    end else if (accept) begin
      state_q <= CONV_RUN;
      cnt_q   <= '0;
      per_q   <= '0;
    end else if (finish) begin
      state_q <= CONV_IDLE;
      cnt_q   <= '0;
      per_q   <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
      if (boundary && (per_q != PER_FULL)) begin
        per_q <= per_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim
  import sinc4_pkg::*;
#(
  parameter int unsigned DECIM = 256,
  parameter int unsigned OUT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_bit,
  input  logic             mod_en,
  input  logic             cont_mode,
  input  logic             start,
  output logic [OUT_W-1:0] result,
  output logic             result_valid
);

  localparam int unsigned ORDER = 4;
  localparam int unsigned LOG2R = $clog2(DECIM);
  localparam int unsigned FRAC  = ORDER * LOG2R;
  localparam int unsigned ACC_W = sinc_acc_width(ORDER, LOG2R);

  logic                    busy;
  logic                    step;
  logic                    boundary;
  logic                    emit;
  logic                    state_clr;
  logic signed [ACC_W-1:0] integ_tap;
  logic signed [ACC_W-1:0] comb_out;
  logic        [OUT_W-1:0] sat_word;

  sinc4_ctrl #(
    .DECIM (DECIM),
    .ORDER (ORDER)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .cont_mode (cont_mode),
    .start     (start),
    .busy      (busy),
    .step      (step),
    .boundary  (boundary),
    .emit      (emit),
    .state_clr (state_clr)
  );

  sinc4_integ #(
    .ORDER (ORDER),
    .ACC_W (ACC_W)
  ) u_integ (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_clr),
    .en     (step),
    .bit_in (mod_bit),
    .tap    (integ_tap)
  );

  sinc4_comb #(
    .ORDER (ORDER),
    .ACC_W (ACC_W)
  ) u_comb (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_clr),
    .load  (boundary),
    .din   (integ_tap),
    .dout  (comb_out)
  );

  sinc4_scale #(
    .ACC_W (ACC_W),
    .OUT_W (OUT_W),
    .FRAC  (FRAC)
  ) u_scale (
    .din  (comb_out),
    .dout (sat_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= emit;
      if (emit) begin
        result <= sat_word;
      end
    end
  end

endmodule

// File: rtl/sinc4_decim_chk.sv
module sinc4_decim_chk #(
  parameter int unsigned DECIM = 256,
  parameter int unsigned ORDER = 4,
  parameter int unsigned ACC_W = 34,
  parameter int unsigned OUT_W = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    mod_en,
  input logic                    cont_mode,
  input logic                    start,
  input logic                    busy,
  input logic                    state_clr,
  input logic signed [ACC_W-1:0] tap,
  input logic        [OUT_W-1:0] result,
  input logic                    result_valid
);

  int ck_cnt;
  int ck_per;

  // Independent sample and period count since the last clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_cnt <= 0;
      ck_per <= 0;
    end else if (state_clr) begin
      ck_cnt <= 0;
      ck_per <= 0;
    end else if (busy && mod_en) begin
      if (ck_cnt == int'(DECIM) - 1) begin
        ck_cnt <= 0;
        if (ck_per < int'(ORDER)) ck_per <= ck_per + 1;
      end else begin
        ck_cnt <= ck_cnt + 1;
      end
    end
  end

  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));

  p_primed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> ($past(busy && mod_en) && ($past(ck_cnt) == int'(DECIM) - 1)
                      && ($past(ck_per) >= int'(ORDER) - 1)));

  p_single_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !$past(cont_mode) && !$past(start)) |-> !busy);

  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tap == '0));

endmodule

bind sinc4_decim sinc4_decim_chk #(
  .DECIM (DECIM),
  .ORDER (ORDER),
  .ACC_W (ACC_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mod_en       (mod_en),
  .cont_mode    (cont_mode),
  .start        (start),
  .busy         (busy),
  .state_clr    (state_clr),
  .tap          (integ_tap),
  .result       (result),
  .result_valid (result_valid)
);

// File: tb/sinc4_decim_tb.sv
module sinc4_decim_tb;

  localparam int R    = 256;
  localparam int SH   = 4 * 8 - 23;
  localparam int HLEN = 4 * R - 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_bit = 1'b0;
  logic        mod_en = 1'b0;
  logic        cont_mode = 1'b0;
  logic        start = 1'b0;
  logic [23:0] result;
  logic        result_valid;

  sinc4_decim #(.DECIM(R), .OUT_W(24)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mod_bit      (mod_bit),
    .mod_en       (mod_en),
    .cont_mode    (cont_mode),
    .start        (start),
    .result       (result),
    .result_valid (result_valid)
  );

  always #10 clk = ~clk;

  int     n_checks = 0;
  int     n_err    = 0;
  string  tag      = "R8";
  longint h [0:4*R];
  logic   hist [0:4095];
  bit     m_active = 1'b0;
  int     m_n      = 0;
  int     n_emits  = 0;
  logic        exp_valid = 1'b0;
  logic [23:0] exp_res   = 24'h0;

  task automatic check(string what, logic [23:0] act, logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic pat(int kind, int i);
    int unsigned v;
    v = (int'(i) + 7) * 32'd2654435761;
    case (kind)
      0: return 1'b1;
      1: return 1'b0;
      2: return (i % 2) == 0;
      3: return (i % 4) != 3;
      4: return (i % 4) == 0;
      default: return v[17];
    endcase
  endfunction

  // Sinc weights: fourfold convolution of an R-long window of ones.
  task automatic build_weights();
    longint t [0:4*R];
    for (int i = 0; i <= 4 * R; i++) h[i] = (i < R) ? 1 : 0;
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i <= 4 * R; i++) begin
        t[i] = 0;
        for (int k = 0; k < R; k++) if (i - k >= 0) t[i] += h[i-k];
      end
      for (int i = 0; i <= 4 * R; i++) h[i] = t[i];
    end
  endtask

  function automatic logic [23:0] model_word(int n);
    longint acc = 0;
    longint sc;
    for (int j = 0; j < HLEN; j++) begin
      int idx = n - 3 - j;
      if (idx >= 1) acc += hist[idx] ? h[j] : -h[j];
    end
    sc = acc >>> SH;
    if (sc > 64'sd8388607) return 24'h7FFFFF;
    if (sc < -64'sd8388608) return 24'h800000;
    return sc[23:0];
  endfunction

  // One clock: check outputs of the previous edge, drive, update the model.
  task automatic cyc(logic en, logic b, logic st, logic cm);
    bit was_active;
    bit fin;
    @(negedge clk);
    check("result_valid (R6)", {23'd0, result_valid}, {23'd0, exp_valid});
    check("result (R1)", result, exp_res);
    mod_en = en; mod_bit = b; start = st; cont_mode = cm;
    exp_valid = 1'b0;
    was_active = m_active;
    fin = 1'b0;
    if (m_active && en) begin
      m_n++;
      hist[m_n] = b;
      if ((m_n % R) == 0 && m_n >= 4 * R) begin
        exp_valid = 1'b1;
        exp_res   = model_word(m_n);
        n_emits++;
        if (!cm) begin
          m_active = 1'b0;
          fin = 1'b1;
        end
      end
    end
    if (st && (!was_active || fin)) begin
      m_active = 1'b1;
      m_n = 0;
    end
  endtask

  task automatic idle_cycles(int k);
    for (int i = 0; i < k; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic conv_single(int kind, bit gaps);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4 * R; i++) begin
      if (gaps && (i % 3) == 0) cyc(1'b0, ~pat(kind, i), 1'b0, 1'b0); // R7
      cyc(1'b1, pat(kind, i), 1'b0, 1'b0);
    end
    idle_cycles(2);
  endtask

  task automatic t_reset();
    tag = "R8";
    check("valid after reset", {23'd0, result_valid}, 24'h0);
    check("result after reset", result, 24'h0);
    tag = "R2 idle";
    for (int i = 0; i < 300; i++) cyc(1'b1, pat(5, i), 1'b0, 1'b0);
    check("result without start", result, 24'h0);
  endtask

  task automatic t_full_scale();
    tag = "R4 ones";  conv_single(0, 1'b0); check("clamp high", result, 24'h7FFFFF);
    tag = "R4 zeros"; conv_single(1, 1'b0); check("clamp low", result, 24'h800000);
    tag = "R4 alt";   conv_single(2, 1'b0); check("midscale", result, 24'h000000);
  endtask

  task automatic t_density();
    tag = "R1 3of4"; conv_single(3, 1'b0); check("half positive", result, 24'h400000);
    tag = "R1 1of4"; conv_single(4, 1'b0); check("half negative", result, 24'hC00000);
    tag = "R1/R7 random gaps"; conv_single(5, 1'b1);
  endtask

  task automatic t_single_clear();
    int e0;
    tag = "R2 clear";
    conv_single(0, 1'b0);
    e0 = n_emits;
    for (int i = 0; i < 400; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    check("no word while idle", n_emits[23:0], e0[23:0]);
    conv_single(2, 1'b0);
    check("fresh state after single", result, 24'h000000);
  endtask

  task automatic t_continuous();
    int e0;
    tag = "R3 free-run";
    e0 = n_emits;
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 6 * R; i++) cyc(1'b1, pat(3, i), 1'b0, 1'b1);
    check("steady word", result, 24'h400000);
    for (int i = 0; i < R; i++) cyc(1'b1, pat(5, i), (i == 40), 1'b1); // R5 start ignored
    for (int i = 0; i < R; i++) cyc(1'b1, pat(5, i + R), 1'b0, (i < R - 1));
    check("word count", 24'(n_emits - e0), 24'd5);
    for (int i = 0; i < 300; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    check("stopped after mode drop", 24'(n_emits - e0), 24'd5);
  endtask

  task automatic t_start_busy();
    tag = "R5 busy";
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4 * R; i++) cyc(1'b1, 1'b1, (i == 500), 1'b0);
    idle_cycles(2);
    check("start ignored", result, 24'h7FFFFF);
  endtask

  task automatic t_back_to_back();
    tag = "R5 same-cycle";
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4 * R; i++) cyc(1'b1, pat(0, i), (i == 4 * R - 1), 1'b0);
    for (int i = 0; i < 4 * R; i++) cyc(1'b1, pat(4, i), 1'b0, 1'b0);
    idle_cycles(2);
    check("second conversion", result, 24'hC00000);
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    build_weights();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_scale();
    t_density();
    t_single_clear();
    t_continuous();
    t_start_busy();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule